// File: doc/BRIEF.md
# SPI Slave Serial Front End with Hold

This block sits between the pins of an SPI slave memory device and its command engine. It runs on a fast system clock. It samples chip select, serial clock, serial data in and the hold input once per system cycle, and it finds their edges itself. Bits are taken on rising SCK and moved out on falling SCK, most significant bit first in both directions. Each completed byte reaches the engine as `rx_byte` with a one-cycle `rx_valid` strobe. The engine keeps the next outgoing byte on `tx_byte`, and the block loads it at the start of a frame and on the falling SCK edge that follows each byte boundary. `sdo_oe` is the enable of an external tri-state driver. Both SPI clock mode 0 (SCK idle low) and mode 3 (SCK idle high) work.

Control is a four-state machine, `fe_state_t`:
- `FE_IDLE`: not selected.
- `FE_LIVE`: a transfer is in progress.
- `FE_PAUSED`: the transfer is frozen by the hold input.
- `FE_MUTED`: the engine rejected the frame.

Transitions:
- start: `FE_IDLE` to `FE_LIVE` on a falling chip select.
- pause: `FE_LIVE` to `FE_PAUSED` when hold falls while SCK is low.
- resume: `FE_PAUSED` to `FE_LIVE` when hold rises while SCK is low.
- mute: `FE_LIVE` or `FE_PAUSED` to `FE_MUTED` when `abort` is asserted.
- release: any state to `FE_IDLE` while chip select is high.

On every select and deselect the block emits a one-cycle pulse. The deselect pulse carries a flag that tells whether the frame ended on a whole byte.

Top module: `spi_fe_top`

## Requirements
- R1: After reset, `sdo_oe`, `rx_valid`, `sel_start` and `sel_end` are all 0.
- R2: Bits on `sdi` are taken on rising SCK, MSB first. After every eighth such bit of a frame, `rx_byte` holds the byte and `rx_valid` pulses for exactly one cycle.
- R3: `sdo` presents `tx_byte` MSB first and changes only on falling SCK. The first byte is loaded when chip select falls. Each further byte is loaded on the first falling SCK after a byte boundary.
- R4: In mode 3, any falling SCK before the first rising SCK of a frame leaves `sdo` unchanged, so bit 7 of the first byte is still presented at the first rising edge.
- R5: While `cs_n` is 1, `sdo_oe` is 0, and SCK or `sdi` activity produces no `rx_valid`.
- R6: Hold is entered only by a falling `hold_n` while SCK is low, and it is left only by a rising `hold_n` while SCK is low. A falling `hold_n` while SCK is high has no effect, even if `hold_n` then stays low.
- R7: While held, `sdo_oe` is 0, the bit counter and both shift registers stay frozen, and `sdi` is ignored. After resume the byte continues from the bit where it paused.
- R8: A cycle with `abort` high during a selected frame forces `sdo_oe` to 0 and suppresses `rx_valid` until the next falling chip select.
- R9: A falling chip select resets the bit counter to zero and raises `sel_start` for one cycle.
- R10: A rising chip select raises `sel_end` for one cycle. `sel_end_aligned` is 1 when the frame held a whole number of bytes and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCK |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| hold_n | input | 1 | Hold request, active low |
| abort | input | 1 | Engine rejects the frame; output stays quiet until reselect |
| tx_byte | input | WORD_W | Next byte to be shifted out |
| rx_byte | output | WORD_W | Last byte received |
| rx_valid | output | 1 | One-cycle strobe for `rx_byte` |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output driver enable (0 means high impedance) |
| sel_start | output | 1 | One-cycle pulse on select |
| sel_end | output | 1 | One-cycle pulse on deselect |
| sel_end_aligned | output | 1 | Valid with `sel_end`: the frame ended on a byte boundary |

## Verification
Every pin edge appears at the outputs one system clock after the first clock edge that samples it:
- A rising SCK gives `rx_byte` and `rx_valid`.
- A falling SCK gives the new `sdo` bit.
- Chip select gives the state change, `sdo_oe`, and `sel_start` or `sel_end`.
- Hold gives the change of `sdo_oe`.

The bench changes one pin at a time on the falling system clock edge. Each level then stays for four system clocks, and `sdo`, `sdo_oe` and the state are sampled at the end of that window, long after the one-cycle latency. The single-cycle strobes are counted by a monitor on the falling clock edge. The checks compare those counts and the captured byte and flag after each scenario.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
    typedef enum logic [1:0] {
        FE_IDLE   = 2'd0,
        FE_LIVE   = 2'd1,
        FE_PAUSED = 2'd2,
        FE_MUTED  = 2'd3
    } fe_state_t;
endpackage

// File: rtl/spi_fe_edges.sv
module spi_fe_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic hold_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_fall,
    output logic cs_rise,
    output logic hold_fall,
    output logic hold_rise
);
    logic sck_q, cs_q, hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q  <= 1'b0;
            cs_q   <= 1'b1;
            hold_q <= 1'b1;
        end else begin
            sck_q  <= sck;
            cs_q   <= cs_n;
            hold_q <= hold_n;
        end
    end

    always_comb begin
        sck_rise  = sck & ~sck_q;
        sck_fall  = ~sck & sck_q;
        cs_fall   = ~cs_n & cs_q;
        cs_rise   = cs_n & ~cs_q;
        hold_fall = ~hold_n & hold_q;
        hold_rise = hold_n & ~hold_q;
    end
endmodule

// File: rtl/spi_fe_rx.sv
module spi_fe_rx #(
    parameter int WORD_W = 8,
    localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              take,
    input  logic              sdi,
    output logic [WORD_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic              got_bit
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);
    logic [WORD_W-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr       <= '0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
            bit_cnt  <= '0;
            got_bit  <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (clear) begin
                bit_cnt <= '0;
                got_bit <= 1'b0;
            end else if (take) begin
                sr      <= {sr[WORD_W-2:0], sdi};
                got_bit <= 1'b1;
                if (bit_cnt == LAST) begin
                    bit_cnt  <= '0;
                    rx_byte  <= {sr[WORD_W-2:0], sdi};
                    rx_valid <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    // R2
    rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
endmodule

// File: rtl/spi_fe_tx.sv
module spi_fe_tx #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [WORD_W-1:0] tx_byte,
    output logic              sdo
);
    logic [WORD_W-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sr <= '0;
        else if (load)   sr <= tx_byte;
        else if (shift)  sr <= {sr[WORD_W-2:0], 1'b0};
    end

    assign sdo = sr[WORD_W-1];
endmodule

// File: rtl/spi_fe_top.sv
module spi_fe_top #(
    parameter int WORD_W = 8,
    localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              sdi,
    input  logic              hold_n,
    input  logic              abort,
    input  logic [WORD_W-1:0] tx_byte,
    output logic [WORD_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              sel_start,
    output logic              sel_end,
    output logic              sel_end_aligned
);
    import spi_fe_pkg::*;

    fe_state_t state, state_nx;
    logic sck_rise, sck_fall, cs_fall, cs_rise, hold_fall, hold_rise;
    logic [CNT_W-1:0] bit_cnt;
    logic got_bit, live, take, tx_load, tx_shift;

    spi_fe_edges u_edges (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_fall(cs_fall),
        .cs_rise(cs_rise), .hold_fall(hold_fall), .hold_rise(hold_rise)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FE_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (cs_n) begin
            state_nx = FE_IDLE;
        end else begin
            unique case (state)
                FE_IDLE:   if (cs_fall) state_nx = FE_LIVE;
                FE_LIVE:   if (abort) state_nx = FE_MUTED;
                           else if (hold_fall && !sck) state_nx = FE_PAUSED;
                FE_PAUSED: if (abort) state_nx = FE_MUTED;
                           else if (hold_rise && !sck) state_nx = FE_LIVE;
                FE_MUTED:  state_nx = FE_MUTED;
                default:   state_nx = FE_IDLE;
            endcase
        end
    end

    // Datapath controls
    always_comb begin
        live     = (state == FE_LIVE) && !cs_n;
        take     = live && sck_rise;
        tx_load  = (state == FE_IDLE && cs_fall) ||
                   (live && sck_fall && got_bit && bit_cnt == '0);
        tx_shift = live && sck_fall && got_bit && bit_cnt != '0;
    end

    spi_fe_rx #(.WORD_W(WORD_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .clear(cs_fall), .take(take), .sdi(sdi),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .bit_cnt(bit_cnt), .got_bit(got_bit)
    );

    spi_fe_tx #(.WORD_W(WORD_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .load(tx_load), .shift(tx_shift),
        .tx_byte(tx_byte), .sdo(sdo)
    );

    // Output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_start       <= 1'b0;
            sel_end         <= 1'b0;
            sel_end_aligned <= 1'b0;
        end else begin
            sel_start <= (state == FE_IDLE) && cs_fall;
            sel_end   <= cs_rise;
            if (cs_rise) sel_end_aligned <= (bit_cnt == '0);
        end
    end

    assign sdo_oe = (state == FE_LIVE);

    // R5
    desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !sdo_oe);
    // R6
    pause_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != FE_PAUSED) ##1 (state == FE_PAUSED) |-> !$past(sck));
    // R7
    pause_no_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FE_PAUSED) |=> !rx_valid);
    // R8
    muted_no_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FE_MUTED && !cs_n) |=> !rx_valid);
    // R9
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_start |=> !sel_start);
    // R10
    end_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_end |-> !sdo_oe);
endmodule

// File: tb/spi_fe_top_tb_top.sv
module spi_fe_top_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, hold_n = 1'b1, abort = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic [7:0] rx_byte;
    logic rx_valid, sdo, sdo_oe, sel_start, sel_end, sel_end_aligned;

    int n_chk = 0, n_bad = 0;
    int rx_cnt = 0, start_cnt = 0, end_cnt = 0;
    logic [7:0] rx_last = 8'h00;
    logic end_flag = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    spi_fe_top #(.WORD_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .hold_n(hold_n), .abort(abort), .tx_byte(tx_byte),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .sdo(sdo), .sdo_oe(sdo_oe),
        .sel_start(sel_start), .sel_end(sel_end), .sel_end_aligned(sel_end_aligned)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid)  begin rx_cnt++; rx_last = rx_byte; end
            if (sel_start) start_cnt++;
            if (sel_end)   begin end_cnt++; end_flag = sel_end_aligned; end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b, output logic so);
        sck = 1'b0; sdi = b; wait_clk(4);
        so = sdo;
        sck = 1'b1; wait_clk(4);
    endtask

    task automatic send_byte(input logic [7:0] mosi, output logic [7:0] miso);
        for (int i = 7; i >= 0; i--) begin
            logic so;
            send_bit(mosi[i], so);
            miso[i] = so;
        end
    endtask

    task automatic select(input logic idle_lvl);
        sck = idle_lvl; wait_clk(4);
        cs_n = 1'b0; wait_clk(4);
    endtask

    task automatic deselect(input logic idle_lvl);
        sck = idle_lvl; wait_clk(4);
        cs_n = 1'b1; wait_clk(4);
    endtask

    task automatic t_reset;
        chk("R1 oe", sdo_oe, 0);
        chk("R1 rx_valid", rx_valid, 0);
        chk("R1 sel_start", sel_start, 0);
        chk("R1 sel_end", sel_end, 0);
    endtask

    task automatic t_mode0_two;
        logic [7:0] so;
        int r0 = rx_cnt, s0 = start_cnt, e0 = end_cnt;
        tx_byte = 8'hA5;
        select(1'b0);
        chk("R9 sel_start", start_cnt - s0, 1);
        chk("R3 oe", sdo_oe, 1);
        send_byte(8'h3C, so);
        chk("R3 tx byte0", so, 8'hA5);
        chk("R2 rx byte0", rx_last, 8'h3C);
        chk("R2 rx count0", rx_cnt - r0, 1);
        tx_byte = 8'h5A;
        send_byte(8'hC3, so);
        chk("R3 tx byte1", so, 8'h5A);
        chk("R2 rx byte1", rx_last, 8'hC3);
        chk("R2 rx count1", rx_cnt - r0, 2);
        deselect(1'b0);
        chk("R10 end count", end_cnt - e0, 1);
        chk("R10 aligned", end_flag, 1);
        chk("R5 oe after", sdo_oe, 0);
    endtask

    task automatic t_mode3;
        logic [7:0] so;
        int r0 = rx_cnt;
        tx_byte = 8'h96;
        select(1'b1);
        send_byte(8'h81, so);
        chk("R4 tx mode3", so, 8'h96);
        chk("R2 rx mode3", rx_last, 8'h81);
        chk("R2 count mode3", rx_cnt - r0, 1);
        deselect(1'b1);
        sck = 1'b0; wait_clk(4);
    endtask

    task automatic t_desel_ignored;
        int r0 = rx_cnt;
        for (int i = 0; i < 8; i++) begin
            sck = 1'b0; sdi = i[0]; wait_clk(4);
            sck = 1'b1; wait_clk(4);
        end
        sck = 1'b0; wait_clk(4);
        chk("R5 no rx", rx_cnt - r0, 0);
        chk("R5 oe", sdo_oe, 0);
    endtask

    task automatic t_hold;
        logic [7:0] so;
        logic b;
        int r0 = rx_cnt;
        tx_byte = 8'h6B;
        select(1'b0);
        for (int i = 7; i >= 4; i--) begin send_bit(1'(8'hB4 >> i), b); so[i] = b; end
        sck = 1'b0; wait_clk(4);
        hold_n = 1'b0; wait_clk(4);
        chk("R7 oe held", sdo_oe, 0);
        for (int i = 0; i < 3; i++) begin
            sdi = ~sdi; sck = 1'b1; wait_clk(4);
            sck = 1'b0; wait_clk(4);
        end
        chk("R7 no rx held", rx_cnt - r0, 0);
        hold_n = 1'b1; wait_clk(4);
        chk("R6 resumed oe", sdo_oe, 1);
        for (int i = 3; i >= 0; i--) begin send_bit(1'(8'hB4 >> i), b); so[i] = b; end
        chk("R7 rx after hold", rx_last, 8'hB4);
        chk("R7 tx after hold", so, 8'h6B);
        chk("R7 count", rx_cnt - r0, 1);
        deselect(1'b0);
    endtask

    task automatic t_hold_high_ignored;
        logic [7:0] so;
        logic b;
        int r0 = rx_cnt;
        tx_byte = 8'hE1;
        select(1'b0);
        send_bit(1'b0, b); so[7] = b;
        hold_n = 1'b0; wait_clk(2);
        for (int i = 6; i >= 0; i--) begin
            send_bit(1'(8'h4D >> i), b); so[i] = b;
            if (i == 6) chk("R6 oe not held", sdo_oe, 1);
        end
        hold_n = 1'b1; wait_clk(2);
        chk("R6 rx", rx_last, 8'h4D);
        chk("R6 count", rx_cnt - r0, 1);
        chk("R6 tx", so, 8'hE1);
        deselect(1'b0);
    endtask

    task automatic t_abort;
        logic [7:0] so;
        int r0 = rx_cnt;
        tx_byte = 8'h11;
        select(1'b0);
        send_byte(8'h9F, so);
        abort = 1'b1; wait_clk(1); abort = 1'b0; wait_clk(3);
        chk("R8 oe muted", sdo_oe, 0);
        send_byte(8'h77, so);
        chk("R8 no rx", rx_cnt - r0, 1);
        chk("R8 oe still", sdo_oe, 0);
        deselect(1'b0);
        tx_byte = 8'hF0;
        select(1'b0);
        chk("R8 oe reselect", sdo_oe, 1);
        send_byte(8'h28, so);
        chk("R8 rx reselect", rx_last, 8'h28);
        chk("R8 tx reselect", so, 8'hF0);
        deselect(1'b0);
    endtask

    task automatic t_partial;
        logic [7:0] so;
        logic b;
        int e0 = end_cnt;
        tx_byte = 8'h3E;
        select(1'b0);
        for (int i = 0; i < 3; i++) send_bit(1'b1, b);
        deselect(1'b0);
        chk("R10 partial end", end_cnt - e0, 1);
        chk("R10 unaligned", end_flag, 0);
        select(1'b0);
        send_byte(8'h6E, so);
        chk("R9 counter reset rx", rx_last, 8'h6E);
        chk("R9 counter reset tx", so, 8'h3E);
        deselect(1'b0);
        chk("R10 aligned again", end_flag, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        wait_clk(3);
        t_reset();
        rst_n = 1'b1;
        wait_clk(3);
        t_reset();
        t_mode0_two();
        t_mode3();
        t_desel_ignored();
        t_hold();
        t_hold_high_ignored();
        t_abort();
        t_partial();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule